// File: doc/BRIEF.md
# Parallel Top-Two Track Sorter with Ghost Cancellation

The block receives a set of candidate track words on every crossing clock. By default there are twelve, two from each of six upstream track finders. Neighbouring finders can reconstruct the same particle from the same detector segments, which produces a false extra track. The block first compares the segment location of each track with the tracks of the finders on either side of its own. When two tracks match, it keeps the stronger one and clears the other.

The surviving candidates then go through a single-stage comparison network. Every candidate is weighed against every other. The two best full track words are forwarded with their valid flags.

The ranking key is built from fields inside the word. Quality sits above transverse momentum, so quality always decides first. Unused output slots carry zero. One crossing clock is spent on cancellation and one on selection, so results appear two cycles after the inputs.

Top module: `trk_top2_sorter`

## Requirements
- R1: While rst_n is low at a clock edge, both best_valid bits and both best_word words are zero after that edge.
- R2: A candidate set sampled at clock edge k appears on best_valid/best_word after edge k+1 (two-cycle latency), and a new set can be accepted on every cycle.
- R3: The rank of a valid track is its bits [30:28] (quality) concatenated above bits [27:23] (transverse momentum). A larger value ranks higher, so a higher quality beats any momentum of a lower quality.
- R4: Among tracks of equal rank, the one with the lower input index ranks higher.
- R5: Track index i belongs to source i/2. Take two valid tracks from adjacent sources (s and s+1) that carry equal cand_loc values. The lower-ranked one is cleared before selection, and on equal rank the lower index is kept.
- R6: Tracks of the same source are never cleared against each other. Sources 0 and 5 are not neighbours.
- R7: Invalid inputs and cleared tracks are never output. If fewer than two tracks remain, each unused slot has best_valid low and best_word zero.
- R8: Slot 0 carries the highest-ranked surviving track and slot 1 the second. best_valid[1] implies best_valid[0].
- R9: The selected 31-bit word is forwarded unchanged, including the bits below the rank fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cand_valid | input | 12 | Valid flag per candidate |
| cand_word | input | 12 x 31 | Full track word per candidate (index 2s, 2s+1 from source s) |
| cand_loc | input | 12 x 6 | Segment location used by each candidate |
| best_valid | output | 2 | Valid flag for slot 0 (best) and slot 1 (second) |
| best_word | output | 2 x 31 | Selected track words, zero when the slot is empty |

## Verification
A wrong cancellation decision shows up two cycles after the offending set. The symptom is either a duplicate pair in both slots or a weaker track in place of the rightful one. A wrong loss count or tie break in the network shows up at the same cycle, as swapped slots, a lower-index tie loser, or a nonzero word in an empty slot. A stage-register fault shifts every result by a cycle, so streamed random sets expose it on the first crossing after reset.

// File: rtl/trksort_pkg.sv
// Package: shared widths, field positions and the ranking helpers.
// Assumes quality occupies the top bits of the word with momentum right below.
package trksort_pkg;
    localparam int WORD_W   = 31;
    localparam int QUAL_W   = 3;
    localparam int PT_W     = 5;
    localparam int KEY_W    = QUAL_W + PT_W;
    localparam int RANK_W   = KEY_W + 1;

    typedef logic [WORD_W-1:0] trk_word_t;
    typedef logic [RANK_W-1:0] trk_rank_t;

    // Rank with a leading presence bit so any valid track beats an empty one.
    function automatic trk_rank_t rank_of(input logic vld, input trk_word_t w);
        return vld ? {1'b1, w[WORD_W-1 -: KEY_W]} : '0;
    endfunction

    // True when candidate a is placed ahead of candidate b.
    function automatic logic ahead_of(input trk_rank_t ra, input int ia,
                                      input trk_rank_t rb, input int ib);
        return (ra > rb) || ((ra == rb) && (ia < ib));
    endfunction
endpackage

// File: rtl/trk_ghost_filter.sv
// Ghost filter: clears a track when a track of an adjacent source uses the
// same segment location and outranks it. Registers survivors (stage 1).
// Assumes candidates are grouped PER_SRC per source in index order.
module trk_ghost_filter
    import trksort_pkg::*;
#(
    parameter int NUM_SRC = 6,
    parameter int PER_SRC = 2,
    parameter int LOC_W   = 6,
    localparam int NCAND  = NUM_SRC * PER_SRC
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NCAND-1:0]             in_valid,
    input  logic [NCAND-1:0][WORD_W-1:0] in_word,
    input  logic [NCAND-1:0][LOC_W-1:0]  in_loc,
    output logic [NCAND-1:0]             s1_valid,
    output logic [NCAND-1:0][WORD_W-1:0] s1_word
);
    logic [NCAND-1:0] keep;

    // Decide per candidate whether an adjacent duplicate outranks it.
    always_comb begin
        for (int i = 0; i < NCAND; i++) begin
            keep[i] = in_valid[i];
            for (int j = 0; j < NCAND; j++) begin
                if (((j / PER_SRC) == (i / PER_SRC) + 1 ||
                     (j / PER_SRC) + 1 == (i / PER_SRC)) &&
                    in_valid[j] && (in_loc[j] == in_loc[i]) &&
                    ahead_of(rank_of(in_valid[j], in_word[j]), j,
                             rank_of(in_valid[i], in_word[i]), i))
                    keep[i] = 1'b0;
            end
        end
    end

    // Stage-1 register of surviving candidates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= '0;
            s1_word  <= '0;
        end else begin
            s1_valid <= keep;
            s1_word  <= in_word;
        end
    end

    // R5: no two adjacent-source survivors may share a location.
    generate
        for (genvar a = 0; a < NCAND; a++) begin : g_dup_a
            for (genvar b = 0; b < NCAND; b++) begin : g_dup_b
                if ((b / PER_SRC) == (a / PER_SRC) + 1) begin : g_adj
                    always_ff @(posedge clk) begin
                        if (rst_n) begin
                            p_no_adjacent_dup_r5: assert (!(keep[a] && keep[b] &&
                                in_loc[a] == in_loc[b]))
                                else $error("adjacent duplicate survived %0d %0d", a, b);
                        end
                    end
                end
            end
        end
    endgenerate

    // R7: a registered survivor was a valid input one cycle earlier.
    p_survivor_was_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid & ~$past(in_valid)) == '0);
endmodule

// File: rtl/trk_rank_select.sv
// Rank select: single-stage all-pairs comparison. Each candidate counts how
// many others are ahead of it; count 0 goes to slot 0, count 1 to slot 1.
// Assumes a strict total order (ties broken by index) so counts are unique.
module trk_rank_select
    import trksort_pkg::*;
#(
    parameter int NCAND   = 12,
    localparam int LOSS_W = $clog2(NCAND + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NCAND-1:0]             s1_valid,
    input  logic [NCAND-1:0][WORD_W-1:0] s1_word,
    output logic [1:0]                   best_valid,
    output logic [1:0][WORD_W-1:0]       best_word
);
    trk_rank_t              rank  [NCAND];
    logic [LOSS_W-1:0]      behind[NCAND];
    logic [1:0]             pick_valid;
    logic [1:0][WORD_W-1:0] pick_word;

    // All-pairs comparison and one-hot style OR merge of the two winners.
    always_comb begin
        for (int i = 0; i < NCAND; i++)
            rank[i] = rank_of(s1_valid[i], s1_word[i]);
        pick_valid = '0;
        pick_word  = '0;
        for (int i = 0; i < NCAND; i++) begin
            behind[i] = '0;
            for (int j = 0; j < NCAND; j++)
                if (j != i && ahead_of(rank[j], j, rank[i], i))
                    behind[i] = behind[i] + LOSS_W'(1);
            if (s1_valid[i] && behind[i] == LOSS_W'(0)) begin
                pick_valid[0] = 1'b1;
                pick_word[0]  = pick_word[0] | s1_word[i];
            end
            if (s1_valid[i] && behind[i] == LOSS_W'(1)) begin
                pick_valid[1] = 1'b1;
                pick_word[1]  = pick_word[1] | s1_word[i];
            end
        end
    end

    // Output register (stage 2).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_valid <= '0;
            best_word  <= '0;
        end else begin
            best_valid <= pick_valid;
            best_word  <= pick_word;
        end
    end

    // R8: slot 1 is used only behind slot 0, and never outranks it.
    p_slot_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        best_valid[1] |-> (best_valid[0] &&
            best_word[0][WORD_W-1 -: KEY_W] >= best_word[1][WORD_W-1 -: KEY_W]));
    // R7: an empty slot carries zero data.
    p_empty_slot_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !best_valid[0] |-> best_word[0] == '0);
    p_empty_slot1_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !best_valid[1] |-> best_word[1] == '0);
    // R7: no more slots filled than survivors presented a cycle earlier.
    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(best_valid) <= $countones($past(s1_valid)));
endmodule

// File: rtl/trk_top2_sorter.sv
// Top: ghost cancellation stage followed by the parallel top-two select.
// Latency two clocks; accepts a new candidate set each clock.
module trk_top2_sorter
    import trksort_pkg::*;
#(
    parameter int NUM_SRC = 6,
    parameter int PER_SRC = 2,
    parameter int LOC_W   = 6,
    localparam int NCAND  = NUM_SRC * PER_SRC
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NCAND-1:0]             cand_valid,
    input  logic [NCAND-1:0][WORD_W-1:0] cand_word,
    input  logic [NCAND-1:0][LOC_W-1:0]  cand_loc,
    output logic [1:0]                   best_valid,
    output logic [1:0][WORD_W-1:0]       best_word
);
    logic [NCAND-1:0]             s1_valid;
    logic [NCAND-1:0][WORD_W-1:0] s1_word;

    trk_ghost_filter #(.NUM_SRC(NUM_SRC), .PER_SRC(PER_SRC), .LOC_W(LOC_W)) u_ghost (
        .clk(clk), .rst_n(rst_n),
        .in_valid(cand_valid), .in_word(cand_word), .in_loc(cand_loc),
        .s1_valid(s1_valid), .s1_word(s1_word));

    trk_rank_select #(.NCAND(NCAND)) u_select (
        .clk(clk), .rst_n(rst_n),
        .s1_valid(s1_valid), .s1_word(s1_word),
        .best_valid(best_valid), .best_word(best_word));
endmodule

// File: tb/trk_top2_sorter_tb_top.sv
module trk_top2_sorter_tb_top;
    localparam int NC = 12;
    localparam int LW = 6;

    logic                clk = 1'b0;
    logic                rst_n;
    logic [NC-1:0]       cand_valid;
    logic [NC-1:0][30:0] cand_word;
    logic [NC-1:0][LW-1:0] cand_loc;
    logic [1:0]          best_valid;
    logic [1:0][30:0]    best_word;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [1:0]       hv;
    logic [1:0]       hx_v [2];
    logic [1:0][30:0] hx_w [2];
    string            hx_t [2];

    trk_top2_sorter dut_i (
        .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid),
        .cand_word(cand_word), .cand_loc(cand_loc),
        .best_valid(best_valid), .best_word(best_word));

    always #10 clk = ~clk;

    // Bench rank: quality in [30:28] above momentum in [27:23].
    function automatic int score(input logic [30:0] w);
        return int'(w[30:28]) * 32 + int'(w[27:23]);
    endfunction

    function automatic logic [30:0] mk(input int q, input int pt, input int rest);
        return {q[2:0], pt[4:0], rest[22:0]};
    endfunction

    function automatic void model(input logic [NC-1:0] v, input logic [NC-1:0][30:0] w,
                                  input logic [NC-1:0][LW-1:0] l,
                                  output logic [1:0] ev, output logic [1:0][30:0] ew);
        logic [NC-1:0] alive;
        int best;
        alive = v;
        for (int i = 0; i < NC; i++)
            for (int j = 0; j < NC; j++) begin
                int si = i / 2;
                int sj = j / 2;
                if ((sj == si + 1 || si == sj + 1) && v[i] && v[j] && l[i] == l[j] &&
                    (score(w[j]) > score(w[i]) || (score(w[j]) == score(w[i]) && j < i)))
                    alive[i] = 1'b0;
            end
        ev = '0;
        ew = '0;
        for (int s = 0; s < 2; s++) begin
            best = -1;
            for (int i = 0; i < NC; i++)
                if (alive[i] && (best < 0 || score(w[i]) > score(w[best]))) best = i;
            if (best >= 0) begin
                ev[s] = 1'b1;
                ew[s] = w[best];
                alive[best] = 1'b0;
            end
        end
    endfunction

    task automatic compare(input logic [1:0] ev, input logic [1:0][30:0] ew, input string tag);
        n_cmp++;
        if (best_valid !== ev || best_word !== ew) begin
            n_bad++;
            $display("FAIL %s: got v=%b w0=%h w1=%h expected v=%b w0=%h w1=%h",
                     tag, best_valid, best_word[0], best_word[1], ev, ew[0], ew[1]);
        end
    endtask

    // One crossing: check the set presented two cycles ago, then drive a new one.
    task automatic step(input logic [NC-1:0] v, input logic [NC-1:0][30:0] w,
                        input logic [NC-1:0][LW-1:0] l, input string tag);
        logic [1:0] ev;
        logic [1:0][30:0] ew;
        @(negedge clk);
        if (hv[1]) compare(hx_v[1], hx_w[1], hx_t[1]);
        hv[1] = hv[0]; hx_v[1] = hx_v[0]; hx_w[1] = hx_w[0]; hx_t[1] = hx_t[0];
        model(v, w, l, ev, ew);
        hv[0] = 1'b1; hx_v[0] = ev; hx_w[0] = ew; hx_t[0] = tag;
        cand_valid = v; cand_word = w; cand_loc = l;
    endtask

    initial begin
        logic [NC-1:0]         v;
        logic [NC-1:0][30:0]   w;
        logic [NC-1:0][LW-1:0] l;
        int seed_dummy;
        seed_dummy = $urandom(32'd1234);
        hv = '0;
        rst_n = 1'b0;
        cand_valid = '0; cand_word = '0; cand_loc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(2'b00, '0, "R1 reset");
        rst_n = 1'b1;

        // R7: nothing valid.
        v = '0; w = '0; l = '0;
        for (int i = 0; i < NC; i++) w[i] = mk(7, 31, i);
        step(v, w, l, "R7 all invalid");
        // R7 R9: single valid track, low fields preserved.
        v = '0; v[7] = 1'b1; w[7] = mk(1, 2, 23'h5a5a5);
        step(v, w, l, "R7 R9 single track");
        // R3: quality dominates momentum.
        v = '0; w = '0; l = '0;
        v[0] = 1'b1; w[0] = mk(1, 31, 11); l[0] = 6'd1;
        v[3] = 1'b1; w[3] = mk(2, 0, 22);  l[3] = 6'd2;
        step(v, w, l, "R3 quality over momentum");
        // R4: equal rank, lower index first.
        v = '0; w = '0; l = '0;
        v[9] = 1'b1; w[9] = mk(4, 9, 99); l[9] = 6'd3;
        v[4] = 1'b1; w[4] = mk(4, 9, 44); l[4] = 6'd7;
        step(v, w, l, "R4 tie by index");
        // R5: adjacent ghost, stronger one kept.
        v = '0; w = '0; l = '0;
        v[2] = 1'b1;  w[2] = mk(3, 3, 2);   l[2] = 6'd9;
        v[5] = 1'b1;  w[5] = mk(5, 1, 5);   l[5] = 6'd9;
        v[10] = 1'b1; w[10] = mk(1, 1, 10); l[10] = 6'd4;
        step(v, w, l, "R5 ghost rank");
        // R5: adjacent ghost with equal rank, lower index kept.
        v = '0; w = '0; l = '0;
        v[2] = 1'b1;  w[2] = mk(6, 6, 2);   l[2] = 6'd12;
        v[4] = 1'b1;  w[4] = mk(6, 6, 4);   l[4] = 6'd12;
        v[11] = 1'b1; w[11] = mk(0, 4, 11); l[11] = 6'd1;
        step(v, w, l, "R5 ghost tie");
        // R6: same-source equal locations survive.
        v = '0; w = '0; l = '0;
        v[0] = 1'b1; w[0] = mk(2, 2, 1); l[0] = 6'd5;
        v[1] = 1'b1; w[1] = mk(3, 3, 2); l[1] = 6'd5;
        step(v, w, l, "R6 same source");
        // R6: first and last sources are not neighbours.
        v = '0; w = '0; l = '0;
        v[1]  = 1'b1; w[1]  = mk(4, 4, 1);  l[1]  = 6'd8;
        v[10] = 1'b1; w[10] = mk(4, 2, 10); l[10] = 6'd8;
        step(v, w, l, "R6 ends not adjacent");

        // R2 R8 R9: streamed random sets with frequent ties and duplicates.
        for (int n = 0; n < 400; n++) begin
            for (int i = 0; i < NC; i++) begin
                v[i] = ($urandom % 10) < 6;
                w[i] = mk(int'($urandom % 8), int'($urandom % 4), int'($urandom));
                l[i] = LW'($urandom % 4);
            end
            step(v, w, l, "R2 R5 R8 R9 random");
        end
        v = '0;
        step(v, w, l, "R7 flush");
        step(v, w, l, "R7 flush");
        step(v, w, l, "R7 flush");
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule